// File: doc/BRIEF.md
# Interrupt Acknowledge Instruction Jammer

This block sits beside a processor whose address, data and status share one 8-bit bus and which reports its bus cycle type on a 3-bit state code. A peripheral asks for service with a rising edge on a request line and a 3-bit vector number. The block holds that request and raises the processor's interrupt line. It then waits for the processor to signal an interrupt acknowledge on the state code.

On the next instruction fetch, during the data part of that fetch only, the block drives a one-byte restart opcode onto the bus. It also holds back normal memory so that memory does not drive the bus at the same time. The processor runs that opcode as a call to address vector×8. Once the single jam is done, the block returns to idle. It does not save any processor state; that is left to other hardware.

Top module: `irq_jam_ctrl`

## Requirements
- R1: During and right after reset, `int_o`, `bus_drive_o` and `mem_inhibit_o` are low and `jam_byte_o` is 0. A request line that is held high across the release of reset is not taken as a request.
- R2: In idle, a low-to-high change of `req_i` seen at a clock edge makes `int_o` high from the next cycle, and it stays high until the request is acknowledged.
- R3: The vector on `vec_i` is captured at the clock edge that accepts the request. Later changes on `vec_i` do not change the byte that is jammed.
- R4: Further rising edges on `req_i` while a request is pending or acknowledged are ignored. They do not move `int_o`, they do not change the captured vector, and they start no second interrupt after the jam.
- R5: While a request is pending, a state code equal to 3'b011 (the acknowledge code) at a clock edge drops `int_o` from the next cycle. Any other state code leaves the request pending.
- R6: An acknowledge code that arrives while idle has no effect. A later fetch strobe does not drive the bus.
- R7: While the request is still pending and not yet acknowledged, `fetch_data_i` does not enable the bus drive.
- R8: After the acknowledge, in the first cycle with `fetch_data_i` high, `bus_drive_o` and `mem_inhibit_o` go high in that same cycle and `jam_byte_o` = {2'b00, vector, 3'b101}, which equals vector×8+5.
- R9: The drive lasts exactly one cycle, and the block is idle afterwards. A new request needs a fresh rising edge on `req_i`.
- R10: `jam_byte_o` is 0 and `mem_inhibit_o` is low in every cycle in which `bus_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Interrupt request; a rising edge asks for service |
| vec_i | input | 3 | Restart vector number for the request |
| state_code_i | input | 3 | Processor state code |
| fetch_data_i | input | 1 | High during the data phase of an instruction fetch |
| int_o | output | 1 | Interrupt line to the processor |
| bus_drive_o | output | 1 | Enables the jam byte onto the data bus |
| jam_byte_o | output | 8 | Restart opcode to place on the bus |
| mem_inhibit_o | output | 1 | Keeps memory off the bus during the jam |

## Verification
Two kinds of result are registered and one is not. The request edge and the acknowledge code each take effect on `int_o` one clock after the edge that samples them, so the bench drives these inputs on the falling edge and reads `int_o` on the next falling edge. The jam outputs follow `fetch_data_i` within the same cycle, so the bench reads them shortly after raising the strobe and before the next rising edge. After that edge it reads them again to confirm that the drive lasted a single cycle. Random vectors, noise on the state code, and extra request pulses are mixed with directed cases, and every expected opcode comes from a bench function.

// File: rtl/irq_jam_pkg.sv
package irq_jam_pkg;
  localparam int VEC_W  = 3;
  localparam int DATA_W = 8;
  localparam int PAD_W  = DATA_W - VEC_W - 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_ACKED = 2'd2
  } jam_state_e;

  // one-byte restart: 00 vvv 101
  function automatic logic [DATA_W-1:0] restart_opcode(input logic [VEC_W-1:0] v);
    return {{PAD_W{1'b0}}, v, 3'b101};
  endfunction
endpackage

// File: rtl/req_capture.sv
module req_capture
  import irq_jam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             accept_i,
  output logic             rise_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  // req_q resets high so a level held through reset is no edge
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        vec_q <= '0;
    else if (accept_i) vec_q <= vec_i;
  end

  assign vec_o = vec_q;

  assert_vec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(vec_q));
endmodule

// File: rtl/jam_seq.sv
module jam_seq
  import irq_jam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       ack_hit_i,
  input  logic       fetch_i,
  output jam_state_e state_o,
  output logic       accept_o,
  output logic       fire_o
);
  jam_state_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && rise_i;
  assign fire_o   = (st_q == ST_ACKED) && fetch_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (rise_i)    st_d = ST_PEND;
      ST_PEND:  if (ack_hit_i) st_d = ST_ACKED;
      ST_ACKED: if (fetch_i)   st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (st_q == ST_IDLE) && !fire_o);
  assert_ack_leaves_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND) && ack_hit_i |=> st_q == ST_ACKED);
  assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !rise_i |=> st_q == ST_IDLE);
endmodule

// File: rtl/jam_drive.sv
module jam_drive
  import irq_jam_pkg::*;
(
  input  logic              fire_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              drive_o,
  output logic              inhibit_o,
  output logic [DATA_W-1:0] byte_o
);
  assign drive_o   = fire_i;
  assign inhibit_o = fire_i;
  assign byte_o    = fire_i ? restart_opcode(vec_i) : '0;

  always_comb begin
    if (fire_i) assert_opcode_form_R8: assert (byte_o[2:0] == 3'b101 && byte_o[DATA_W-1:VEC_W+3] == '0);
  end
endmodule

// File: rtl/irq_jam_ctrl.sv
module irq_jam_ctrl
  import irq_jam_pkg::*;
#(
  parameter int             STATE_W  = 3,
  parameter logic [STATE_W-1:0] ACK_CODE = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [STATE_W-1:0] state_code_i,
  input  logic               fetch_data_i,
  output logic               int_o,
  output logic               bus_drive_o,
  output logic [DATA_W-1:0]  jam_byte_o,
  output logic               mem_inhibit_o
);
  logic             req_rise;
  logic             accept;
  logic             ack_hit;
  logic             jam_fire;
  logic [VEC_W-1:0] held_vec;
  jam_state_e       seq_state;

  assign ack_hit = (state_code_i == ACK_CODE);

  req_capture u_cap (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_i(vec_i),
    .accept_i(accept), .rise_o(req_rise), .vec_o(held_vec)
  );

  jam_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rise_i(req_rise), .ack_hit_i(ack_hit),
    .fetch_i(fetch_data_i), .state_o(seq_state), .accept_o(accept), .fire_o(jam_fire)
  );

  jam_drive u_drv (
    .fire_i(jam_fire), .vec_i(held_vec),
    .drive_o(bus_drive_o), .inhibit_o(mem_inhibit_o), .byte_o(jam_byte_o)
  );

  assign int_o = (seq_state == ST_PEND);

  assert_int_drive_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_o && bus_drive_o));
  assert_inhibit_needs_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit_o |-> fetch_data_i && bus_drive_o);
  assert_int_drops_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o && ack_hit |=> !int_o);
  assert_int_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_o && !ack_hit |=> int_o);
  assert_idle_byte_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_o |-> jam_byte_o == '0);
endmodule

// File: tb/sim_irq_jam_ctrl.sv
module sim_irq_jam_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] vec_i = '0;
  logic [2:0] state_code_i = '0;
  logic       fetch_data_i = 1'b0;
  logic       int_o, bus_drive_o, mem_inhibit_o;
  logic [7:0] jam_byte_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_jam_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_i(vec_i),
    .state_code_i(state_code_i), .fetch_data_i(fetch_data_i),
    .int_o(int_o), .bus_drive_o(bus_drive_o), .jam_byte_o(jam_byte_o),
    .mem_inhibit_o(mem_inhibit_o)
  );

  function automatic logic [7:0] exp_op(input logic [2:0] v);
    return 8'(int'(v) * 8 + 5);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_outs(input string tag);
    chk({tag, " int"}, {7'd0, int_o}, 8'd0);
    chk({tag, " drv"}, {7'd0, bus_drive_o}, 8'd0);
    chk({tag, " inh"}, {7'd0, mem_inhibit_o}, 8'd0);
    chk({tag, " byte"}, jam_byte_o, 8'd0);
  endtask

  function automatic logic [2:0] noise_code();
    logic [2:0] c;
    c = 3'($urandom_range(0, 7));
    if (c == 3'b011) c = 3'b110;
    return c;
  endfunction

  // one full request/ack/jam sequence with noise
  task automatic one_irq(input logic [2:0] v, input bit noisy);
    logic [2:0] other;
    req_i = 1'b0; vec_i = v; tick();
    req_i = 1'b1; tick();
    chk("R2 int after edge", {7'd0, int_o}, 8'd1);
    other = ~v; vec_i = other;
    if (noisy) begin
      req_i = 1'b0; tick();
      req_i = 1'b1; vec_i = 3'($urandom_range(0, 7)); tick();
      chk("R4 int unchanged by extra edge", {7'd0, int_o}, 8'd1);
      for (int k = 0; k < 3; k++) begin
        state_code_i = noise_code(); tick();
        chk("R5 non-ack code keeps int", {7'd0, int_o}, 8'd1);
      end
      state_code_i = 3'b000;
      fetch_data_i = 1'b1; #1;
      chk("R7 no drive before ack", {7'd0, bus_drive_o}, 8'd0);
      chk("R10 byte zero before ack", jam_byte_o, 8'd0);
      tick(); fetch_data_i = 1'b0;
    end
    state_code_i = 3'b011; tick();
    state_code_i = 3'b000;
    chk("R5 int dropped after ack", {7'd0, int_o}, 8'd0);
    chk("R10 no drive before fetch", {7'd0, bus_drive_o}, 8'd0);
    if (noisy) begin
      req_i = 1'b0; tick(); req_i = 1'b1; tick();
      chk("R4 edge while acked ignored", {7'd0, int_o}, 8'd0);
    end
    fetch_data_i = 1'b1; #1;
    chk("R8 drive", {7'd0, bus_drive_o}, 8'd1);
    chk("R8 inhibit", {7'd0, mem_inhibit_o}, 8'd1);
    chk("R3 R8 jam byte", jam_byte_o, exp_op(v));
    tick();
    chk("R9 drive one cycle", {7'd0, bus_drive_o}, 8'd0);
    chk("R9 int idle", {7'd0, int_o}, 8'd0);
    fetch_data_i = 1'b0; tick();
    chk("R4 no second irq", {7'd0, int_o}, 8'd0);
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    req_i = 1'b1;
    repeat (3) @(negedge clk);
    idle_outs("R1 in reset");
    rst_n = 1'b1; tick(); tick();
    idle_outs("R1 held req not taken");

    // R6: ack while idle, then fetch
    req_i = 1'b0; state_code_i = 3'b011; tick();
    state_code_i = 3'b000; fetch_data_i = 1'b1; #1;
    chk("R6 idle ack no drive", {7'd0, bus_drive_o}, 8'd0);
    tick(); fetch_data_i = 1'b0;

    // directed corner vectors
    one_irq(3'd0, 1'b0);
    one_irq(3'd7, 1'b1);

    // R9: request held high after jam needs a fresh edge
    tick(); tick();
    chk("R9 no fresh edge", {7'd0, int_o}, 8'd0);

    for (int t = 0; t < 40; t++) begin
      one_irq(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule